// File: doc/BRIEF.md
# 8-bit Arithmetic/Logic Unit with Condition Flags

This unit is the purely combinational datapath slice of a small 8-bit RISC core. The core's decoder supplies a 4-bit operation code and two byte operands. The second operand is either a register or an instruction constant, and the unit does not tell the two apart. The decoder also supplies the stored carry flag and the stored zero flag. In the same cycle the unit returns the byte result, a flag vector laid out like the core's status register, and a flag write mask. The core's status register loads only the flag bits whose mask bit is 1 and keeps every other bit.

The operation set covers:
- add and subtract, each with and without the incoming carry;
- bitwise AND, OR and XOR;
- one's complement and two's complement;
- increment and decrement;
- logical shift right, arithmetic shift right, rotate right through carry and rotate left through carry;
- exchange of the two nibbles.

Every operation writes its own fixed set of flags. The subtract-with-carry operation ANDs its zero result with the stored zero flag. This lets a chain of byte subtractions or compares report equality across the full multi-byte width.

Top module: `alu8_core`

## Requirements
- R1: Operation code values are ADD=0, ADC=1, SUB=2, SBC=3, AND=4, OR=5, XOR=6, COM=7, NEG=8, INC=9, DEC=10, LSR=11, ASR=12, ROR=13, ROL=14, SWAP=15.
- R2: Flag bit positions in both `flag_val` and `flag_wr` are: bit 5 H, bit 4 S, bit 3 V, bit 2 N, bit 1 Z, bit 0 C. Bits 7 and 6 are always 0. A flag bit whose mask bit is 0 reads 0.
- R3: ADD returns a+b and ignores `carry_in`. ADC returns a+b+`carry_in`. Both write H, S, V, N, Z and C, where C is the carry out of bit 7, H is the carry out of bit 3, and V is signed overflow.
- R4: SUB returns a-b. SBC returns a-b-`carry_in`. Both write all six flags, where C is the borrow out of bit 7, H is the borrow out of bit 3, and V is signed overflow.
- R5: For SBC, Z is 1 only when the result is zero and `zero_in` is 1. For every other operation that writes Z, Z is 1 exactly when the result is zero.
- R6: AND, OR and XOR write only S, V, N and Z, and V is 0.
- R7: INC and DEC write only S, V, N and Z. V is 1 only for INC of 0x7F and DEC of 0x80.
- R8: COM returns 0xFF-a, writes S, V, N, Z and C, and sets C to 1 and V to 0.
- R9: NEG returns 0x00-a and writes all six flags. C is 1 when the result is nonzero, V is 1 when the result is 0x80, and H is the borrow out of bit 3.
- R10: LSR fills bit 7 with 0. ASR keeps bit 7. ROR moves `carry_in` into bit 7. ROL moves `carry_in` into bit 0. C takes the bit shifted out, and all four write S, V, N, Z and C with V = N xor C.
- R11: SWAP exchanges the two nibbles and writes no flag (mask 0x00).
- R12: Whenever N is written, S equals N xor V.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 4 | Decoded operation (encoding in R1) |
| opnd_a | input | 8 | Destination-register operand |
| opnd_b | input | 8 | Source register or constant operand |
| carry_in | input | 1 | Stored carry flag |
| zero_in | input | 1 | Stored zero flag, used by SBC |
| result | output | 8 | Byte result |
| flag_val | output | 8 | New flag values in status-register layout |
| flag_wr | output | 8 | One bit per flag: 1 means the operation writes that flag |

## Verification
The unit holds no state, so a fault in any internal path shows at the ports in the same cycle that the inputs change. The sensitive internal signals are the carries out of bit 3 and bit 7, the choice between the adder, logic and shifter results, and the per-operation mask. An error in any of them appears at once as a wrong result byte, a wrong flag bit, or a mask bit that is set or cleared for the wrong operation. The zero-chaining rule is exercised with the same zero result under both values of the stored zero flag. The carry-related rules are exercised with carries crossing bit 3, bit 7, and both bits.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    parameter int DW = 8;
    localparam int NW = DW / 2;
    localparam int FW = 6;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBC  = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_COM  = 4'd7,
        OP_NEG  = 4'd8,
        OP_INC  = 4'd9,
        OP_DEC  = 4'd10,
        OP_LSR  = 4'd11,
        OP_ASR  = 4'd12,
        OP_ROR  = 4'd13,
        OP_ROL  = 4'd14,
        OP_SWAP = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        LG_AND,
        LG_OR,
        LG_XOR,
        LG_NOT
    } logic_sel_e;

    typedef enum logic [2:0] {
        SH_LSR,
        SH_ASR,
        SH_ROR,
        SH_ROL,
        SH_SWAP
    } shift_sel_e;

    typedef enum logic [1:0] {
        SRC_ARITH,
        SRC_LOGIC,
        SRC_SHIFT
    } res_src_e;

    // Six writable condition flags, most significant first: H S V N Z C
    typedef struct packed {
        logic h;
        logic s;
        logic v;
        logic n;
        logic z;
        logic c;
    } flag6_t;

    // Control word produced by the operation decoder
    typedef struct packed {
        res_src_e   src;
        logic       sub;
        logic       use_cin;
        logic       a_zero;
        logic       b_one;
        logic_sel_e lsel;
        shift_sel_e ssel;
    } alu_ctl_t;

    function automatic flag6_t flag_mask(alu_op_e op);
        flag6_t m;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG:
                m = 6'b111111;
            OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC:
                m = 6'b011110;
            OP_COM, OP_LSR, OP_ASR, OP_ROR, OP_ROL:
                m = 6'b011111;
            default:
                m = 6'b000000;
        endcase
        return m;
    endfunction

    function automatic logic [DW-1:0] to_sreg(flag6_t f);
        return {{(DW-FW){1'b0}}, f};
    endfunction

endpackage

// File: rtl/alu8_decode.sv
module alu8_decode
    import alu8_pkg::*;
(
    input  alu_op_e  op,
    output alu_ctl_t ctl
);

    always_comb begin
        ctl.src     = SRC_ARITH;
        ctl.sub     = 1'b0;
        ctl.use_cin = 1'b0;
        ctl.a_zero  = 1'b0;
        ctl.b_one   = 1'b0;
        ctl.lsel    = LG_AND;
        ctl.ssel    = SH_LSR;
        case (op)
            OP_ADD:  ;
            OP_ADC:  ctl.use_cin = 1'b1;
            OP_SUB:  ctl.sub = 1'b1;
            OP_SBC:  begin ctl.sub = 1'b1; ctl.use_cin = 1'b1; end
            OP_NEG:  begin ctl.sub = 1'b1; ctl.a_zero = 1'b1; end
            OP_INC:  ctl.b_one = 1'b1;
            OP_DEC:  begin ctl.sub = 1'b1; ctl.b_one = 1'b1; end
            OP_AND:  begin ctl.src = SRC_LOGIC; ctl.lsel = LG_AND; end
            OP_OR:   begin ctl.src = SRC_LOGIC; ctl.lsel = LG_OR;  end
            OP_XOR:  begin ctl.src = SRC_LOGIC; ctl.lsel = LG_XOR; end
            OP_COM:  begin ctl.src = SRC_LOGIC; ctl.lsel = LG_NOT; end
            OP_LSR:  begin ctl.src = SRC_SHIFT; ctl.ssel = SH_LSR;  end
            OP_ASR:  begin ctl.src = SRC_SHIFT; ctl.ssel = SH_ASR;  end
            OP_ROR:  begin ctl.src = SRC_SHIFT; ctl.ssel = SH_ROR;  end
            OP_ROL:  begin ctl.src = SRC_SHIFT; ctl.ssel = SH_ROL;  end
            OP_SWAP: begin ctl.src = SRC_SHIFT; ctl.ssel = SH_SWAP; end
            default: ;
        endcase
    end

endmodule

// File: rtl/alu8_addsub.sv
module alu8_addsub
    import alu8_pkg::*;
#(
    parameter int W  = DW,
    parameter int HB = NW
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         c_out,
    output logic         h_out,
    output logic         v_out
);

    localparam int WF = W + 1;
    localparam int WH = HB + 1;

    logic [W:0]  full;
    logic [HB:0] low;

    always_comb begin
        if (sub) begin
            full = {1'b0, x} - {1'b0, y} - WF'(cin);
            low  = {1'b0, x[HB-1:0]} - {1'b0, y[HB-1:0]} - WH'(cin);
        end else begin
            full = {1'b0, x} + {1'b0, y} + WF'(cin);
            low  = {1'b0, x[HB-1:0]} + {1'b0, y[HB-1:0]} + WH'(cin);
        end
        sum   = full[W-1:0];
        c_out = full[W];
        h_out = low[HB];
        if (sub)
            v_out = (x[W-1] & ~y[W-1] & ~full[W-1]) | (~x[W-1] & y[W-1] & full[W-1]);
        else
            v_out = (x[W-1] & y[W-1] & ~full[W-1]) | (~x[W-1] & ~y[W-1] & full[W-1]);
    end

    // Equal operands with no borrow must subtract to zero (R4)
    always_comb begin
        if (sub && !cin && x == y)
            assert_equal_diff_R4: assert (sum == '0 && !c_out);
    end

endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
    import alu8_pkg::*;
#(
    parameter int W = DW
) (
    input  logic_sel_e   lsel,
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] res
);

    always_comb begin
        case (lsel)
            LG_AND:  res = x & y;
            LG_OR:   res = x | y;
            LG_XOR:  res = x ^ y;
            default: res = ~x;
        endcase
    end

endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
    import alu8_pkg::*;
#(
    parameter int W = DW
) (
    input  shift_sel_e   ssel,
    input  logic [W-1:0] x,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         c_out
);

    localparam int HW = W / 2;

    logic [W-1:0] swapped;

    generate
        if (W % 2 == 0) begin : g_even
            assign swapped = {x[HW-1:0], x[W-1:HW]};
        end else begin : g_odd
            assign swapped = {x[HW-1:0], x[HW], x[W-1:HW+1]};
        end
    endgenerate

    always_comb begin
        res   = x;
        c_out = x[0];
        case (ssel)
            SH_LSR: res = {1'b0, x[W-1:1]};
            SH_ASR: res = {x[W-1], x[W-1:1]};
            SH_ROR: res = {cin, x[W-1:1]};
            SH_ROL: begin
                res   = {x[W-2:0], cin};
                c_out = x[W-1];
            end
            SH_SWAP: begin
                res   = swapped;
                c_out = 1'b0;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/alu8_flagger.sv
module alu8_flagger
    import alu8_pkg::*;
#(
    parameter int W = DW
) (
    input  alu_op_e      op,
    input  res_src_e     src,
    input  logic [W-1:0] res,
    input  logic         ar_c,
    input  logic         ar_h,
    input  logic         ar_v,
    input  logic         sh_c,
    input  logic         zero_in,
    output flag6_t       val,
    output flag6_t       mask
);

    flag6_t raw;
    logic   res_zero;

    assign res_zero = (res == '0);

    always_comb begin
        raw.n = res[W-1];
        raw.z = (op == OP_SBC) ? (res_zero & zero_in) : res_zero;
        raw.h = ar_h;
        case (src)
            SRC_ARITH: begin
                raw.c = ar_c;
                raw.v = ar_v;
            end
            SRC_LOGIC: begin
                raw.c = (op == OP_COM);
                raw.v = 1'b0;
            end
            default: begin
                raw.c = sh_c;
                raw.v = res[W-1] ^ sh_c;
            end
        endcase
        raw.s = raw.n ^ raw.v;
        mask  = flag_mask(op);
        val   = raw & mask;
    end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic [3:0] op_code,
    input  logic [7:0] opnd_a,
    input  logic [7:0] opnd_b,
    input  logic       carry_in,
    input  logic       zero_in,
    output logic [7:0] result,
    output logic [7:0] flag_val,
    output logic [7:0] flag_wr
);

    alu_op_e      op;
    alu_ctl_t     ctl;
    logic [DW-1:0] ax, ay, ar_res, lg_res, sh_res;
    logic          ar_cin, ar_c, ar_h, ar_v, sh_c;
    flag6_t        fval, fmask;

    assign op = alu_op_e'(op_code);

    alu8_decode u_dec (
        .op  (op),
        .ctl (ctl)
    );

    assign ax     = ctl.a_zero ? '0 : opnd_a;
    assign ay     = ctl.a_zero ? opnd_a : (ctl.b_one ? DW'(1) : opnd_b);
    assign ar_cin = ctl.use_cin & carry_in;

    alu8_addsub #(.W(DW), .HB(NW)) u_arith (
        .x     (ax),
        .y     (ay),
        .cin   (ar_cin),
        .sub   (ctl.sub),
        .sum   (ar_res),
        .c_out (ar_c),
        .h_out (ar_h),
        .v_out (ar_v)
    );

    alu8_bitops #(.W(DW)) u_logic (
        .lsel (ctl.lsel),
        .x    (opnd_a),
        .y    (opnd_b),
        .res  (lg_res)
    );

    alu8_shift #(.W(DW)) u_shift (
        .ssel  (ctl.ssel),
        .x     (opnd_a),
        .cin   (carry_in),
        .res   (sh_res),
        .c_out (sh_c)
    );

    always_comb begin
        case (ctl.src)
            SRC_ARITH: result = ar_res;
            SRC_LOGIC: result = lg_res;
            default:   result = sh_res;
        endcase
    end

    alu8_flagger #(.W(DW)) u_flags (
        .op      (op),
        .src     (ctl.src),
        .res     (result),
        .ar_c    (ar_c),
        .ar_h    (ar_h),
        .ar_v    (ar_v),
        .sh_c    (sh_c),
        .zero_in (zero_in),
        .val     (fval),
        .mask    (fmask)
    );

    assign flag_val = to_sreg(fval);
    assign flag_wr  = to_sreg(fmask);

    // Port-level guards
    always_comb begin
        if (op == OP_ADD)
            assert_add_sum_R3: assert ({flag_val[0], result} == {1'b0, opnd_a} + {1'b0, opnd_b});
        if (op == OP_SUB)
            assert_sub_borrow_R4: assert (flag_val[0] == (opnd_a < opnd_b));
        if (op == OP_SBC && result != 8'h00)
            assert_zero_chain_R5: assert (flag_val[1] == 1'b0);
        if (op == OP_AND || op == OP_OR || op == OP_XOR)
            assert_logic_vclr_R6: assert (flag_val[3] == 1'b0 && flag_wr[0] == 1'b0 && flag_wr[5] == 1'b0);
        if (op == OP_SWAP)
            assert_swap_quiet_R11: assert (flag_wr == 8'h00 && result == {opnd_a[3:0], opnd_a[7:4]});
        if (flag_wr[2])
            assert_sign_rule_R12: assert (flag_val[4] == (flag_val[2] ^ flag_val[3]));
    end

endmodule

// File: tb/test_alu8_core.sv
module test_alu8_core;
    import alu8_pkg::*;

    logic       clk = 1'b0;
    logic [3:0] op_code = 4'd0;
    logic [7:0] opnd_a = 8'h00, opnd_b = 8'h00;
    logic       carry_in = 1'b0, zero_in = 1'b0;
    logic [7:0] result, flag_val, flag_wr;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    alu8_core i_alu8_core (
        .op_code  (op_code),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .carry_in (carry_in),
        .zero_in  (zero_in),
        .result   (result),
        .flag_val (flag_val),
        .flag_wr  (flag_wr)
    );

    typedef struct packed {
        logic [3:0] op;
        logic [7:0] a;
        logic [7:0] b;
        logic       ci;
        logic       zi;
        logic [7:0] res;
        logic [7:0] fl;
        logic [7:0] mk;
    } vec_t;

    // Flags: bit5 H, bit4 S, bit3 V, bit2 N, bit1 Z, bit0 C
    localparam int NV = 21;
    localparam vec_t VT [NV] = '{
        '{4'd0,  8'h0F, 8'h01, 1'b0, 1'b0, 8'h10, 8'h20, 8'h3F}, // R3 half carry
        '{4'd0,  8'h7F, 8'h01, 1'b0, 1'b0, 8'h80, 8'h2C, 8'h3F}, // R3 overflow
        '{4'd0,  8'h01, 8'h01, 1'b1, 1'b0, 8'h02, 8'h00, 8'h3F}, // R3 cin ignored
        '{4'd1,  8'hFF, 8'h00, 1'b1, 1'b0, 8'h00, 8'h23, 8'h3F}, // R3 adc wrap
        '{4'd2,  8'h10, 8'h01, 1'b0, 1'b0, 8'h0F, 8'h20, 8'h3F}, // R4 half borrow
        '{4'd2,  8'h80, 8'h01, 1'b0, 1'b0, 8'h7F, 8'h38, 8'h3F}, // R4 overflow
        '{4'd3,  8'h05, 8'h05, 1'b0, 1'b0, 8'h00, 8'h00, 8'h3F}, // R5 chain z held low
        '{4'd3,  8'h05, 8'h05, 1'b0, 1'b1, 8'h00, 8'h02, 8'h3F}, // R5 chain z kept
        '{4'd3,  8'h00, 8'h00, 1'b1, 1'b1, 8'hFF, 8'h35, 8'h3F}, // R4 sbc borrow
        '{4'd4,  8'hF0, 8'h0F, 1'b1, 1'b0, 8'h00, 8'h02, 8'h1E}, // R6 and
        '{4'd6,  8'h80, 8'h00, 1'b0, 1'b0, 8'h80, 8'h14, 8'h1E}, // R6 xor
        '{4'd7,  8'h00, 8'h00, 1'b0, 1'b0, 8'hFF, 8'h15, 8'h1F}, // R8 com
        '{4'd8,  8'h80, 8'h00, 1'b0, 1'b0, 8'h80, 8'h0D, 8'h3F}, // R9 neg 0x80
        '{4'd8,  8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 8'h02, 8'h3F}, // R9 neg zero
        '{4'd9,  8'h7F, 8'h00, 1'b0, 1'b0, 8'h80, 8'h0C, 8'h1E}, // R7 inc
        '{4'd10, 8'h80, 8'h00, 1'b0, 1'b0, 8'h7F, 8'h18, 8'h1E}, // R7 dec
        '{4'd11, 8'h01, 8'h00, 1'b0, 1'b0, 8'h00, 8'h1B, 8'h1F}, // R10 lsr
        '{4'd12, 8'h81, 8'h00, 1'b0, 1'b0, 8'hC0, 8'h15, 8'h1F}, // R10 asr
        '{4'd13, 8'h02, 8'h00, 1'b1, 1'b0, 8'h81, 8'h0C, 8'h1F}, // R10 ror
        '{4'd14, 8'h80, 8'h00, 1'b0, 1'b0, 8'h00, 8'h1B, 8'h1F}, // R10 rol
        '{4'd15, 8'hA5, 8'h00, 1'b1, 1'b1, 8'h5A, 8'h00, 8'h00}  // R11 swap
    };

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                         input logic ci, input logic zi);
        @(posedge clk);
        op_code  = op;
        opnd_a   = a;
        opnd_b   = b;
        carry_in = ci;
        zero_in  = zi;
        @(negedge clk);
    endtask

    function automatic int sgn(input int v);
        return (v >= 128) ? v - 256 : v;
    endfunction

    // Reference model written from the requirements
    task automatic ref_calc(input int op, input int a, input int b, input bit ci, input bit zi,
                            output logic [7:0] r, output logic [7:0] fl, output logic [7:0] mk);
        int t, st, cc;
        bit h, v, c, n, z, s;
        h = 0; v = 0; c = 0;
        t = 0;
        case (op)
            0, 1: begin
                cc = (op == 1) ? int'(ci) : 0;
                t  = a + b + cc;
                c  = (t > 255);
                h  = ((a % 16) + (b % 16) + cc) > 15;
                st = sgn(a) + sgn(b) + cc;
                v  = (st > 127) || (st < -128);
                mk = 8'h3F;
            end
            2, 3: begin
                cc = (op == 3) ? int'(ci) : 0;
                t  = a - b - cc;
                c  = (t < 0);
                h  = ((a % 16) - (b % 16) - cc) < 0;
                st = sgn(a) - sgn(b) - cc;
                v  = (st > 127) || (st < -128);
                mk = 8'h3F;
            end
            4: begin t = a & b; mk = 8'h1E; end
            5: begin t = a | b; mk = 8'h1E; end
            6: begin t = a ^ b; mk = 8'h1E; end
            7: begin t = 255 - a; c = 1; mk = 8'h1F; end
            8: begin
                t = 0 - a;
                c = (a != 0);
                h = (a % 16) != 0;
                v = (a == 128);
                mk = 8'h3F;
            end
            9:  begin t = a + 1; v = (a == 127); mk = 8'h1E; end
            10: begin t = a - 1; v = (a == 128); mk = 8'h1E; end
            11: begin t = a / 2; c = a % 2; mk = 8'h1F; end
            12: begin t = a / 2 + (a & 128); c = a % 2; mk = 8'h1F; end
            13: begin t = a / 2 + (ci ? 128 : 0); c = a % 2; mk = 8'h1F; end
            14: begin t = (a * 2) % 256 + int'(ci); c = a >= 128; mk = 8'h1F; end
            default: begin t = (a % 16) * 16 + a / 16; mk = 8'h00; end
        endcase
        r = t[7:0];
        n = r[7];
        if (op >= 11 && op <= 14) v = n ^ c;
        z = (r == 8'h00) && (op != 3 || zi);
        s = n ^ v;
        fl = {2'b00, h, s, v, n, z, c} & mk;
    endtask

    initial begin : main
        logic [7:0] er, ef, em;
        string tag;
        @(negedge clk);

        // Directed vector table
        for (int i = 0; i < NV; i++) begin
            apply(VT[i].op, VT[i].a, VT[i].b, VT[i].ci, VT[i].zi);
            case (VT[i].op)
                4'd0, 4'd1: tag = "R3";
                4'd2:       tag = "R4";
                4'd3:       tag = (VT[i].ci) ? "R4" : "R5";
                4'd4, 4'd6: tag = "R6";
                4'd7:       tag = "R8";
                4'd8:       tag = "R9";
                4'd9, 4'd10: tag = "R7";
                4'd15:      tag = "R11";
                default:    tag = "R10";
            endcase
            chk(tag, $sformatf("vec%0d result", i), result, VT[i].res);
            chk(tag, $sformatf("vec%0d flags", i), flag_val, VT[i].fl);
            chk("R2", $sformatf("vec%0d mask", i), flag_wr, VT[i].mk);
        end

        // R2: upper status bits never written nor set
        apply(4'd1, 8'hFF, 8'hFF, 1'b1, 1'b1);
        chk("R2", "upper bits", {flag_val[7:6], flag_wr[7:6]}, 8'h00);

        // R5: zero_in has no effect on a non-chaining subtract
        apply(4'd2, 8'h33, 8'h33, 1'b0, 1'b0);
        chk("R5", "sub z ignores zero_in", flag_val, 8'h02);

        // R1/R12: sweep all codes against the reference model
        for (int op = 0; op < 16; op++) begin
            for (int a = 0; a < 256; a += 51) begin
                for (int b = 3; b < 256; b += 50) begin
                    for (int ci = 0; ci < 2; ci++) begin
                        for (int zi = 0; zi < 2; zi++) begin
                            ref_calc(op, a, b, ci[0], zi[0], er, ef, em);
                            apply(op[3:0], a[7:0], b[7:0], ci[0], zi[0]);
                            chk("R1", $sformatf("op%0d a=%02h b=%02h result", op, a, b), result, er);
                            chk("R12", $sformatf("op%0d a=%02h b=%02h flags", op, a, b), flag_val, ef);
                            chk("R1", $sformatf("op%0d mask", op), flag_wr, em);
                        end
                    end
                end
            end
        end

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule